// File: doc/BRIEF.md
# Block Address Translator

This unit maps a 32-bit effective address onto a physical address using a small file of region descriptors. Each descriptor is a pair of 32-bit words, and each pair covers one naturally aligned region between 128 KB and 256 MB. The instruction side and the data side each have their own file of descriptors. A lookup takes an effective address, a privilege flag, an access type and a side select. One cycle later it returns a hit or a miss, the physical address, four memory attribute bits and a protection fault.

Software loads the descriptors one word at a time through a write port. A lookup that misses is meant to fall back to page-based translation elsewhere.

A mask of contiguous low-order ones sets the region size. In every masked position the effective-address bit passes through to the physical address, and the descriptor's own bit is ignored. Each descriptor has two enable bits, one for supervisor accesses and one for user accesses. A descriptor whose enable bit for the current privilege is clear can never match.

Top module: `bat_xlate`

## Requirements
- R1: After reset every descriptor on both sides is cleared, so every lookup misses, and `res_valid` stays 0 until a lookup is requested.
- R2: A lookup presented with `lk_valid`=1 at a clock edge produces its result at the next edge. `res_valid` is 1 exactly in the cycle after a cycle with `lk_valid`=1.
- R3: Upper descriptor word (`wr_lower`=0) bit positions:
  - [31:17] is the effective region index.
  - [16:13] is reserved.
  - [12:2] is the length mask.
  - [1] is the supervisor enable.
  - [0] is the user enable.
- R4: Lower descriptor word (`wr_lower`=1) bit positions:
  - [31:17] is the physical region index.
  - [16:7] is reserved.
  - [6] is write-through, [5] is cache-inhibit, [4] is coherence and [3] is guarded.
  - [2] is reserved.
  - [1:0] is the protection code.
  - On a hit, `res_attr` = {write-through, cache-inhibit, coherence, guarded}.
- R5: A descriptor matches when `lk_ea[31:17]` equals its effective index in every bit position where the zero-extended length mask is 0. Mask 0 gives a 128 KB region and mask 0x7FF gives a 256 MB region.
- R6: On a hit, `res_pa[16:0]` = `lk_ea[16:0]`. `res_pa[31:17]` takes the physical index bit where the mask bit is 0 and the effective-address bit where it is 1.
- R7: A descriptor can match a supervisor lookup (`lk_super`=1) only if its supervisor enable is set. It can match a user lookup only if its user enable is set.
- R8: When several descriptors match, the lowest-numbered one (`wr_idx`) supplies the result.
- R9: `lk_instr`=1 searches only the instruction-side descriptors and `lk_instr`=0 only the data-side ones. `wr_instr` selects the side that is written.
- R10: On a hit, `res_fault` is 1 when the protection code is 00 (any access), or when the code is 01 or 11 and `lk_write`=1. Code 10 never faults.
- R11: The guarded bit written to an instruction-side descriptor is stored as 0, so instruction lookups always report guarded = 0.
- R12: When no descriptor matches, `res_miss`=1, `res_hit`=0, and `res_pa`, `res_attr` and `res_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one descriptor word |
| wr_instr | input | 1 | 1 = instruction side, 0 = data side |
| wr_lower | input | 1 | 1 = lower word, 0 = upper word |
| wr_idx | input | 2 | Descriptor number |
| wr_data | input | 32 | Word to store |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_super | input | 1 | 1 = supervisor, 0 = user |
| lk_write | input | 1 | 1 = store access |
| lk_instr | input | 1 | 1 = instruction fetch |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A descriptor matched |
| res_miss | output | 1 | No descriptor matched |
| res_pa | output | 32 | Physical address |
| res_attr | output | 4 | {write-through, cache-inhibit, coherence, guarded} |
| res_fault | output | 1 | Protection violation |

## Verification
The bench loads descriptors with masks of 0, 0x7 and 0x7FF. A design that compares the masked bits, or that takes the physical address from the wrong source, reports a miss or a wrong `res_pa[31:17]`. Two descriptors cover the same region with different privilege enables, so a lookup that ignores the enables, or that picks the highest-numbered match, returns the wrong region. The protection codes are tried with reads and writes, and a guarded bit is written on both sides: a design that faults on code 10, lets a write through code 11, or keeps the guarded bit on the instruction side shows a wrong `res_fault` or `res_attr`. Addresses that lie just outside a masked region, and lookups on the wrong side, must miss.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int EA_W      = 32;
    localparam int BLK_LSB   = 17;
    localparam int BLK_W     = EA_W - BLK_LSB;
    localparam int LEN_W     = 11;
    localparam int UP_RSV_W  = EA_W - BLK_W - LEN_W - 2;
    localparam int LO_RSV_W  = EA_W - BLK_W - 4 - 1 - 2;
    localparam int DEF_PAIRS = 4;

    typedef enum logic [1:0] {
        PROT_NONE   = 2'b00,
        PROT_RO     = 2'b01,
        PROT_RW     = 2'b10,
        PROT_RO_ALT = 2'b11
    } prot_e;

    typedef struct packed {
        logic [BLK_W-1:0]    eff_idx;
        logic [UP_RSV_W-1:0] rsv;
        logic [LEN_W-1:0]    len_mask;
        logic                sup_en;
        logic                usr_en;
    } bat_upper_t;

    typedef struct packed {
        logic [BLK_W-1:0]    phys_idx;
        logic [LO_RSV_W-1:0] rsv;
        logic                wthru;
        logic                cinh;
        logic                coher;
        logic                guard;
        logic                rsv2;
        prot_e               prot;
    } bat_lower_t;

    typedef struct packed {
        bat_upper_t up;
        bat_lower_t lo;
    } bat_pair_t;

    typedef struct packed {
        logic wthru;
        logic cinh;
        logic coher;
        logic guard;
    } bat_attr_t;

    typedef struct packed {
        logic           hit;
        logic [EA_W-1:0] pa;
        bat_attr_t      attr;
        logic           fault;
    } bat_result_t;

    function automatic logic [BLK_W-1:0] len_to_mask(logic [LEN_W-1:0] len);
        return {{(BLK_W-LEN_W){1'b0}}, len};
    endfunction

    function automatic logic entry_match(bat_upper_t up, logic [BLK_W-1:0] eblk,
                                         logic sup);
        logic enabled;
        enabled = sup ? up.sup_en : up.usr_en;
        return enabled && (((eblk ^ up.eff_idx) & ~len_to_mask(up.len_mask)) == '0);
    endfunction

    function automatic logic [BLK_W-1:0] merge_index(bat_pair_t p,
                                                     logic [BLK_W-1:0] eblk);
        logic [BLK_W-1:0] m;
        m = len_to_mask(p.up.len_mask);
        return (p.lo.phys_idx & ~m) | (eblk & m);
    endfunction

    function automatic logic access_fault(prot_e p, logic is_wr);
        case (p)
            PROT_NONE: return 1'b1;
            PROT_RW:   return 1'b0;
            default:   return is_wr;
        endcase
    endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
    import bat_pkg::*;
#(
    parameter int N        = DEF_PAIRS,
    parameter bit NO_GUARD = 1'b0,
    localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic                 sel_lower,
    input  logic [IW-1:0]        idx,
    input  logic [EA_W-1:0]      wdata,
    output bat_pair_t [N-1:0]    pairs
);

    bat_lower_t lo_in;

    always_comb begin
        lo_in = bat_lower_t'(wdata);
        if (NO_GUARD) lo_in.guard = 1'b0;
    end

    for (genvar e = 0; e < N; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                pairs[e] <= '0;
            end else if (we && (idx == IW'(e))) begin
                if (sel_lower) pairs[e].lo <= lo_in;
                else           pairs[e].up <= bat_upper_t'(wdata);
            end
        end
    end

endmodule

// File: rtl/bat_lookup.sv
module bat_lookup
    import bat_pkg::*;
#(
    parameter int N = DEF_PAIRS
) (
    input  bat_pair_t [N-1:0] pairs,
    input  logic [EA_W-1:0]   ea,
    input  logic              sup,
    input  logic              is_wr,
    output bat_result_t       res
);

    logic [BLK_W-1:0] eblk;
    logic [N-1:0]     hv;
    bat_pair_t        pick;

    assign eblk = ea[EA_W-1:BLK_LSB];

    for (genvar e = 0; e < N; e++) begin : g_cmp
        assign hv[e] = entry_match(pairs[e].up, eblk, sup);
    end

    // lowest index wins: scan from the top so the last assignment is the lowest
    always_comb begin
        pick = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (hv[k]) pick = pairs[k];
        end
    end

    always_comb begin
        res = '0;
        if (|hv) begin
            res.hit   = 1'b1;
            res.pa    = {merge_index(pick, eblk), ea[BLK_LSB-1:0]};
            res.attr  = '{wthru: pick.lo.wthru, cinh: pick.lo.cinh,
                          coher: pick.lo.coher, guard: pick.lo.guard};
            res.fault = access_fault(pick.lo.prot, is_wr);
        end
    end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int N = DEF_PAIRS,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_instr,
    input  logic            wr_lower,
    input  logic [IW-1:0]   wr_idx,
    input  logic [31:0]     wr_data,
    input  logic            lk_valid,
    input  logic [31:0]     lk_ea,
    input  logic            lk_super,
    input  logic            lk_write,
    input  logic            lk_instr,
    output logic            res_valid,
    output logic            res_hit,
    output logic            res_miss,
    output logic [31:0]     res_pa,
    output logic [3:0]      res_attr,
    output logic            res_fault
);

    bat_pair_t [N-1:0] ipairs;
    bat_pair_t [N-1:0] dpairs;
    bat_pair_t [N-1:0] side;
    bat_result_t       comb_res;
    bat_result_t       q_res;
    logic              q_valid;

    bat_regfile #(.N(N), .NO_GUARD(1'b1)) u_iside (
        .clk(clk), .rst(rst), .we(wr_en && wr_instr), .sel_lower(wr_lower),
        .idx(wr_idx), .wdata(wr_data), .pairs(ipairs)
    );

    bat_regfile #(.N(N), .NO_GUARD(1'b0)) u_dside (
        .clk(clk), .rst(rst), .we(wr_en && !wr_instr), .sel_lower(wr_lower),
        .idx(wr_idx), .wdata(wr_data), .pairs(dpairs)
    );

    assign side = lk_instr ? ipairs : dpairs;

    bat_lookup #(.N(N)) u_lookup (
        .pairs(side), .ea(lk_ea), .sup(lk_super), .is_wr(lk_write), .res(comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_res   <= '0;
        end else begin
            q_valid <= lk_valid;
            q_res   <= lk_valid ? comb_res : '0;
        end
    end

    assign res_valid = q_valid;
    assign res_hit   = q_res.hit;
    assign res_miss  = q_valid && !q_res.hit;
    assign res_pa    = q_res.pa;
    assign res_attr  = q_res.attr;
    assign res_fault = q_res.fault;

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [31:0] lk_ea,
    input logic        lk_instr,
    input logic        res_valid,
    input logic        res_hit,
    input logic        res_miss,
    input logic [31:0] res_pa,
    input logic [3:0]  res_attr,
    input logic        res_fault
);

    // R2
    req_to_result_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    // R2
    idle_no_result_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    // R12
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_hit != res_miss));

    // R10
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        res_fault |-> res_hit);

    // R6
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!res_hit || res_pa[16:0] == $past(lk_ea[16:0])));

    // R11
    iside_unguarded_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_instr) |=> !res_attr[0]);

    // R12
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        res_miss |-> (res_pa == '0 && res_attr == '0 && !res_fault));

endmodule

bind bat_xlate bat_xlate_chk u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_instr(lk_instr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_pa(res_pa), .res_attr(res_attr), .res_fault(res_fault)
);

// File: tb/tb_bat_xlate.sv
module tb_bat_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_instr = 1'b0, wr_lower = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        lk_valid = 1'b0, lk_super = 1'b0, lk_write = 1'b0, lk_instr = 1'b0;
    logic [31:0] lk_ea = '0;
    logic        res_valid, res_hit, res_miss, res_fault;
    logic [31:0] res_pa;
    logic [3:0]  res_attr;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bat_xlate dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_instr(wr_instr), .wr_lower(wr_lower),
        .wr_idx(wr_idx), .wr_data(wr_data), .lk_valid(lk_valid), .lk_ea(lk_ea),
        .lk_super(lk_super), .lk_write(lk_write), .lk_instr(lk_instr),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_pa(res_pa), .res_attr(res_attr), .res_fault(res_fault)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkup(logic [14:0] idx, logic [10:0] len,
                                         logic sv, logic uv);
        return {idx, 4'b0, len, sv, uv};
    endfunction

    function automatic logic [31:0] mklo(logic [14:0] idx, logic [3:0] wimg,
                                         logic [1:0] pp);
        return {idx, 10'b0, wimg, 1'b0, pp};
    endfunction

    task automatic wr(logic side_i, logic lower, logic [1:0] idx, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_instr = side_i; wr_lower = lower; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(string req, logic [31:0] ea, logic sup, logic wrt, logic ins,
                        logic eh, logic [31:0] epa, logic [3:0] eattr, logic ef);
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = ea; lk_super = sup; lk_write = wrt; lk_instr = ins;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, "valid", 32'(res_valid), 32'd1);
        check(req, "hit",   32'(res_hit),   32'(eh));
        check(req, "miss",  32'(res_miss),  32'(!eh));
        check(req, "pa",    res_pa,         epa);
        check(req, "attr",  32'(res_attr),  32'(eattr));
        check(req, "fault", 32'(res_fault), 32'(ef));
    endtask

    task automatic t_reset;
        check("R1", "valid after reset", 32'(res_valid), 32'd0);
        look("R1", 32'h0003_1234, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0);
        look("R1", 32'h0003_1234, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0);
    endtask

    task automatic t_load;
        wr(1'b0, 1'b0, 2'd0, mkup(15'h0001, 11'h000, 1'b1, 1'b0));
        wr(1'b0, 1'b1, 2'd0, mklo(15'h0100, 4'b0011, 2'b10));
        wr(1'b0, 1'b0, 2'd1, mkup(15'h0040, 11'h007, 1'b1, 1'b0));
        wr(1'b0, 1'b1, 2'd1, mklo(15'h0200, 4'b0100, 2'b01));
        wr(1'b0, 1'b0, 2'd2, mkup(15'h1000, 11'h7FF, 1'b1, 1'b0));
        wr(1'b0, 1'b1, 2'd2, mklo(15'h4000, 4'b1000, 2'b11));
        wr(1'b0, 1'b0, 2'd3, mkup(15'h0001, 11'h000, 1'b1, 1'b1));
        wr(1'b0, 1'b1, 2'd3, mklo(15'h0300, 4'b0000, 2'b00));
        wr(1'b1, 1'b0, 2'd0, mkup(15'h0001, 11'h000, 1'b1, 1'b1));
        wr(1'b1, 1'b1, 2'd0, mklo(15'h0700, 4'b1001, 2'b10));
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        check("R2", "valid without request", 32'(res_valid), 32'd0);
    endtask

    task automatic t_basic;
        // R3 R4 R5 R6: 128 KB region, offset passes through, attributes reported
        look("R6", 32'h0003_1234, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0201_1234, 4'b0011, 1'b0);
        look("R5", 32'h0002_0000, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0200_0000, 4'b0011, 1'b0);
    endtask

    task automatic t_mask;
        // R5 R6: 1 MB region, masked index bits come from the address
        look("R5", 32'h008D_4321, 1'b1, 1'b0, 1'b0, 1'b1, 32'h040D_4321, 4'b0100, 1'b0);
        look("R5", 32'h0090_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0);
        look("R6", 32'h2ABC_DEF0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8ABC_DEF0, 4'b1000, 1'b0);
        look("R12", 32'hF000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0);
    endtask

    task automatic t_priv_prio;
        // R8: descriptors 0 and 3 both match for supervisor, 0 wins
        look("R8", 32'h0003_1234, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0201_1234, 4'b0011, 1'b0);
        // R7: user cannot use descriptor 0, falls to 3 (code 00 faults)
        look("R7", 32'h0003_1234, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0601_1234, 4'b0000, 1'b1);
        look("R7", 32'h008D_4321, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0);
    endtask

    task automatic t_prot;
        look("R10", 32'h0003_1234, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0201_1234, 4'b0011, 1'b0);
        look("R10", 32'h008D_4321, 1'b1, 1'b1, 1'b0, 1'b1, 32'h040D_4321, 4'b0100, 1'b1);
        look("R10", 32'h2ABC_DEF0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h8ABC_DEF0, 4'b1000, 1'b1);
        look("R10", 32'h2ABC_DEF0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8ABC_DEF0, 4'b1000, 1'b0);
        look("R10", 32'h0003_1234, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0601_1234, 4'b0000, 1'b1);
    endtask

    task automatic t_sides;
        // R9 R11: instruction side has its own descriptor, guard forced to 0
        look("R11", 32'h0003_1234, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0E01_1234, 4'b1000, 1'b0);
        look("R9", 32'h008D_4321, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0);
        look("R9", 32'h0003_1234, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0E01_1234, 4'b1000, 1'b0);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_idle();
        t_basic();
        t_mask();
        t_priv_prio();
        t_prot();
        t_sides();
        finish_run();
    end

endmodule